// File: doc/BRIEF.md
# Radio Front-End Control Sequencer

This block sits between a link controller's frame timing and an external frequency-hopping radio transceiver. From a small set of frame indications (idle, transmit frame, receive frame, correlation phase), a receive-side loop configuration bit and a power-class select, it drives the radio's active-low power enables for the transmitter, receiver, synthesizer loop and chip. It also drives the antenna and power-amplifier switch lines, and three DC-compensation enables whose timing is tied to the start of each correlation phase.

All logic runs from the raw crystal clock. A divider made of an enable counter turns that clock into an 8 MHz base tick. Two strap inputs set the divide ratio, and they are read only while reset is held. Every output is registered on a base tick. The 4 MHz synthesizer reference is produced as a register that toggles on each tick while the radio is active. It is held low while idle.

Top module: `rf_front_seq`

## Requirements
- R1: While `rst_n` is low, `strap_in` is captured and sets the base tick rate: one tick every 2 crystal cycles for code 00, 3 for 01, 4 for 10, and 4 for the reserved code 11. Changes on `strap_in` after reset is released have no effect.
- R2: After reset the outputs sit in the idle state: all of `radio_on_n`, `tx_on_n`, `rx_on_n`, `dc_hold_n`, `dc_pulse_n`, `dc_pwm_n` and `ant_sw_b` are high, and `pll_open_n`, `ant_sw_a`, `pa_on` and `ref_clk_out` are low.
- R3: `radio_on_n` is low exactly while `mode_idle` is low. Every output takes its new value on the first base tick after an input change.
- R4: `tx_on_n` is low only when not idle and `frame_tx` is high. `rx_on_n` is low only when not idle, `frame_rx` is high and `frame_tx` is low, so transmit has priority.
- R5: `pll_open_n` is low (loop open or powered down) when idle, while transmitting, and while receiving with `pll_open_rx_cfg` high. Otherwise it is high.
- R6: `ant_sw_a` is high while transmitting and `ant_sw_b` is its inverse. `pa_on` is high only while transmitting with `high_power` high.
- R7: While not idle, `ref_clk_out` toggles on every base tick, giving high and low runs of one tick each. While idle it stays low.
- R8: `dc_hold_n` is low on every tick where `corr_phase` is seen high and the block is not idle. With `mode_idle` high, `corr_phase` has no effect on any DC-compensation output.
- R9: `dc_pulse_n` is low for the first 120 ticks of a correlation phase and high afterwards.
- R10: `dc_pwm_n` is low for the first 120 ticks of a correlation phase. After that it repeats a period of 7 high ticks followed by 1 low tick.
- R11: When a correlation phase ends early, either inside the 120-tick window or partway through a pulse period, all three DC-compensation outputs go high on the next tick. The next phase starts its window from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal | input | 1 | Crystal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_in | input | 2 | Divide-ratio straps, read during reset |
| mode_idle | input | 1 | High while the link controller is idle |
| frame_tx | input | 1 | Transmit frame in progress |
| frame_rx | input | 1 | Receive frame in progress |
| corr_phase | input | 1 | Correlation phase in progress |
| pll_open_rx_cfg | input | 1 | Open the synthesizer loop during receive |
| high_power | input | 1 | Select the high-power class for transmit |
| radio_on_n | output | 1 | Radio chip enable, active low |
| tx_on_n | output | 1 | Transmitter enable, active low |
| rx_on_n | output | 1 | Receiver enable, active low |
| pll_open_n | output | 1 | Loop open / synthesizer power-down, active low |
| ant_sw_a | output | 1 | Antenna switch line, high on transmit |
| ant_sw_b | output | 1 | Inverse antenna switch line |
| pa_on | output | 1 | External power amplifier enable |
| dc_hold_n | output | 1 | DC compensation held for the whole phase |
| dc_pulse_n | output | 1 | DC compensation for the initial window only |
| dc_pwm_n | output | 1 | DC compensation window then one-in-eight pulses |
| ref_clk_out | output | 1 | Gated synthesizer reference |

## Verification
The bench repeats every test for all four strap codes, so a wrong tick rate appears as a wrong run length in crystal cycles. All 32 combinations of idle, transmit, receive, loop bit and power class are applied in steady state. This separates transmit priority, the receive loop option and idle gating from one another. Correlation phases of 200, 50, 130 and 120 ticks are each compared tick by tick against an arithmetic model. Together they separate a correct window from a mis-sized one, a correct pulse phase from a shifted one, early termination inside the window and inside a pulse period, and a window counter that fails to restart.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    // Divide ratios selected by the reset-time straps
    localparam int DIV_CODE0 = 2;
    localparam int DIV_CODE1 = 3;
    localparam int DIV_CODE2 = 4;
    localparam int DIV_MAX   = 4;
    localparam int DIV_W     = $clog2(DIV_MAX + 1);

    typedef logic [DIV_W-1:0] div_t;

    // Reserved code 11 falls back to the slowest ratio
    function automatic div_t strap_to_div(input logic [1:0] code);
        case (code)
            2'b00:   return div_t'(DIV_CODE0);
            2'b01:   return div_t'(DIV_CODE1);
            default: return div_t'(DIV_CODE2);
        endcase
    endfunction

endpackage

// File: rtl/rfs_clk_div.sv
module rfs_clk_div
    import rfs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] strap,
    output logic       tick
);

    typedef struct packed {
        logic [1:0] code;
        div_t       cnt;
    } div_state_t;

    div_state_t div_d, div_q;
    div_t       limit;

    always_comb begin
        div_d = div_q;
        limit = strap_to_div(div_q.code);
        tick  = 1'b0;
        if (!rst_n) begin
            div_d.code = strap;
            div_d.cnt  = '0;
        end else if (div_q.cnt == limit - div_t'(1)) begin
            div_d.cnt = '0;
            tick      = 1'b1;
        end else begin
            div_d.cnt = div_q.cnt + div_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        div_q <= div_d;
    end

    AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(div_q.code)); // R1
    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> div_q.cnt < limit); // R1

endmodule

// File: rtl/rfs_dc_comp.sv
module rfs_dc_comp #(
    parameter int WIN_TICKS  = 120,
    parameter int PWM_PERIOD = 8,
    parameter int PWM_LOW    = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic corr,
    output logic hold_n,
    output logic pulse_n,
    output logic pwm_n
);

    localparam int CW = $clog2(WIN_TICKS + 1);
    localparam int PW = (PWM_PERIOD > 1) ? $clog2(PWM_PERIOD) : 1;
    localparam int LOW_START = PWM_PERIOD - PWM_LOW;

    typedef struct packed {
        logic          act;
        logic [CW-1:0] cnt;
        logic [PW-1:0] ph;
        logic          hold_n;
        logic          pulse_n;
        logic          pwm_n;
    } dc_state_t;

    dc_state_t     dc_d, dc_q;
    logic [CW-1:0] pos;

    always_comb begin
        dc_d = dc_q;
        pos  = dc_q.act ? dc_q.cnt : '0;
        if (!rst_n) begin
            dc_d = '{act: 1'b0, cnt: '0, ph: '0, hold_n: 1'b1, pulse_n: 1'b1, pwm_n: 1'b1};
        end else if (tick) begin
            if (corr) begin
                dc_d.act    = 1'b1;
                dc_d.hold_n = 1'b0;
                if (pos < CW'(WIN_TICKS)) begin
                    dc_d.pulse_n = 1'b0;
                    dc_d.pwm_n   = 1'b0;
                    dc_d.ph      = '0;
                    dc_d.cnt     = pos + CW'(1);
                end else begin
                    dc_d.pulse_n = 1'b1;
                    dc_d.pwm_n   = !(dc_q.ph >= PW'(LOW_START));
                    dc_d.ph      = (dc_q.ph == PW'(PWM_PERIOD - 1)) ? '0 : dc_q.ph + PW'(1);
                    dc_d.cnt     = pos;
                end
            end else begin
                dc_d = '{act: 1'b0, cnt: '0, ph: '0, hold_n: 1'b1, pulse_n: 1'b1, pwm_n: 1'b1};
            end
        end
    end

    always_ff @(posedge clk) begin
        dc_q <= dc_d;
    end

    assign hold_n  = dc_q.hold_n;
    assign pulse_n = dc_q.pulse_n;
    assign pwm_n   = dc_q.pwm_n;

    AST_HOLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        tick && corr |=> !hold_n); // R8
    AST_PULSE_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_n |-> !hold_n); // R9
    AST_WIN_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        dc_q.cnt <= CW'(WIN_TICKS)); // R9
    AST_PWM_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_n |-> !pwm_n); // R10
    AST_DROP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !corr |=> hold_n && pulse_n && pwm_n); // R11

endmodule

// File: rtl/rfs_ctrl.sv
module rfs_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic idle,
    input  logic tx,
    input  logic rx,
    input  logic open_rx,
    input  logic hi_pwr,
    output logic radio_on_n,
    output logic tx_on_n,
    output logic rx_on_n,
    output logic pll_open_n,
    output logic ant_a,
    output logic ant_b,
    output logic pa_on,
    output logic ref_clk
);

    typedef struct packed {
        logic radio_on_n;
        logic tx_on_n;
        logic rx_on_n;
        logic pll_open_n;
        logic ant_a;
        logic ant_b;
        logic pa_on;
        logic ref_clk;
    } ctl_state_t;

    localparam ctl_state_t CTL_IDLE = '{radio_on_n: 1'b1, tx_on_n: 1'b1, rx_on_n: 1'b1,
                                        pll_open_n: 1'b0, ant_a: 1'b0, ant_b: 1'b1,
                                        pa_on: 1'b0, ref_clk: 1'b0};

    ctl_state_t ctl_d, ctl_q;
    logic       active, tx_act, rx_act;

    always_comb begin
        ctl_d  = ctl_q;
        active = !idle;
        tx_act = active && tx;
        rx_act = active && rx && !tx;
        if (!rst_n) begin
            ctl_d = CTL_IDLE;
        end else if (tick) begin
            ctl_d.radio_on_n = !active;
            ctl_d.tx_on_n    = !tx_act;
            ctl_d.rx_on_n    = !rx_act;
            ctl_d.pll_open_n = !(idle || tx_act || (rx_act && open_rx));
            ctl_d.ant_a      = tx_act;
            ctl_d.ant_b      = !tx_act;
            ctl_d.pa_on      = tx_act && hi_pwr;
            ctl_d.ref_clk    = active ? !ctl_q.ref_clk : 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    assign radio_on_n = ctl_q.radio_on_n;
    assign tx_on_n    = ctl_q.tx_on_n;
    assign rx_on_n    = ctl_q.rx_on_n;
    assign pll_open_n = ctl_q.pll_open_n;
    assign ant_a      = ctl_q.ant_a;
    assign ant_b      = ctl_q.ant_b;
    assign pa_on      = ctl_q.pa_on;
    assign ref_clk    = ctl_q.ref_clk;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        radio_on_n |-> tx_on_n && rx_on_n && !pll_open_n); // R3
    AST_TX_RX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!tx_on_n && !rx_on_n)); // R4
    AST_TX_LOOP_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_on_n |-> !pll_open_n); // R5
    AST_PA_ON_TX: assert property (@(posedge clk) disable iff (!rst_n)
        pa_on |-> !tx_on_n && ant_a); // R6
    AST_ANT_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        ant_a != ant_b); // R6
    AST_REF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        radio_on_n |-> !ref_clk); // R7

endmodule

// File: rtl/rf_front_seq.sv
module rf_front_seq #(
    parameter int WIN_TICKS  = 120,
    parameter int PWM_PERIOD = 8,
    parameter int PWM_LOW    = 1
) (
    input  logic       clk_xtal,
    input  logic       rst_n,
    input  logic [1:0] strap_in,
    input  logic       mode_idle,
    input  logic       frame_tx,
    input  logic       frame_rx,
    input  logic       corr_phase,
    input  logic       pll_open_rx_cfg,
    input  logic       high_power,
    output logic       radio_on_n,
    output logic       tx_on_n,
    output logic       rx_on_n,
    output logic       pll_open_n,
    output logic       ant_sw_a,
    output logic       ant_sw_b,
    output logic       pa_on,
    output logic       dc_hold_n,
    output logic       dc_pulse_n,
    output logic       dc_pwm_n,
    output logic       ref_clk_out
);

    logic base_tick;
    logic corr_eff;

    assign corr_eff = corr_phase && !mode_idle;

    rfs_clk_div i_div (
        .clk   (clk_xtal),
        .rst_n (rst_n),
        .strap (strap_in),
        .tick  (base_tick)
    );

    rfs_ctrl i_ctrl (
        .clk        (clk_xtal),
        .rst_n      (rst_n),
        .tick       (base_tick),
        .idle       (mode_idle),
        .tx         (frame_tx),
        .rx         (frame_rx),
        .open_rx    (pll_open_rx_cfg),
        .hi_pwr     (high_power),
        .radio_on_n (radio_on_n),
        .tx_on_n    (tx_on_n),
        .rx_on_n    (rx_on_n),
        .pll_open_n (pll_open_n),
        .ant_a      (ant_sw_a),
        .ant_b      (ant_sw_b),
        .pa_on      (pa_on),
        .ref_clk    (ref_clk_out)
    );

    rfs_dc_comp #(
        .WIN_TICKS  (WIN_TICKS),
        .PWM_PERIOD (PWM_PERIOD),
        .PWM_LOW    (PWM_LOW)
    ) i_dc (
        .clk     (clk_xtal),
        .rst_n   (rst_n),
        .tick    (base_tick),
        .corr    (corr_eff),
        .hold_n  (dc_hold_n),
        .pulse_n (dc_pulse_n),
        .pwm_n   (dc_pwm_n)
    );

endmodule

// File: tb/test_rf_front_seq.sv
`timescale 1ns/1ps
module test_rf_front_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] strap = 2'b00;
    logic       idle = 1'b1, tx = 1'b0, rx = 1'b0, corr = 1'b0, cfg = 1'b0, hp = 1'b0;
    logic       radio_on_n, tx_on_n, rx_on_n, pll_open_n, ant_a, ant_b, pa_on;
    logic       hold_n, pulse_n, pwm_n, ref_o;

    int checks = 0;
    int fails  = 0;
    int n_div  = 2;
    logic [2:0] smp [0:1023];

    always #5 clk = ~clk;

    rf_front_seq i_rf_front_seq (
        .clk_xtal(clk), .rst_n(rst_n), .strap_in(strap), .mode_idle(idle),
        .frame_tx(tx), .frame_rx(rx), .corr_phase(corr), .pll_open_rx_cfg(cfg),
        .high_power(hp), .radio_on_n(radio_on_n), .tx_on_n(tx_on_n), .rx_on_n(rx_on_n),
        .pll_open_n(pll_open_n), .ant_sw_a(ant_a), .ant_sw_b(ant_b), .pa_on(pa_on),
        .dc_hold_n(hold_n), .dc_pulse_n(pulse_n), .dc_pwm_n(pwm_n), .ref_clk_out(ref_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (strap %0d)", req, act, exp, strap);
        end
    endtask

    function automatic int vec10();
        return {radio_on_n, tx_on_n, rx_on_n, pll_open_n, ant_a, ant_b, pa_on,
                hold_n, pulse_n, pwm_n};
    endfunction

    task automatic do_reset(input logic [1:0] s);
        @(negedge clk);
        rst_n = 1'b0; strap = s; idle = 1'b1; tx = 0; rx = 0; corr = 0; cfg = 0; hp = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        strap = ~s;                      // must be ignored (R1)
        n_div = (s == 2'b00) ? 2 : (s == 2'b01) ? 3 : 4;
        @(negedge clk);
        chk("R2 reset state", {vec10(), ref_o}, 11'b111_0_0_1_0_111_0);
    endtask

    task automatic run_ref();
        int hi = 0, lo = 0, guard = 0, seen = 0;
        @(negedge clk);
        idle = 1'b0; tx = 0; rx = 0; corr = 0;
        repeat (3 * n_div) @(negedge clk);
        while (ref_o !== 1'b0 && guard < 20) begin @(negedge clk); guard++; end
        while (ref_o !== 1'b1 && guard < 40) begin @(negedge clk); guard++; end
        while (ref_o === 1'b1 && hi < 20) begin hi++; @(negedge clk); end
        while (ref_o === 1'b0 && lo < 20) begin lo++; @(negedge clk); end
        chk("R7 ref high run", hi, n_div);
        chk("R1 tick rate from strap (low run)", lo, n_div);
        idle = 1'b1;
        repeat (2 * n_div) @(negedge clk);
        for (int i = 0; i < 4 * n_div; i++) begin
            @(negedge clk);
            if (ref_o !== 1'b0) seen++;
        end
        chk("R7 ref gated in idle", seen, 0);
    endtask

    task automatic run_combos();
        for (int c = 0; c < 32; c++) begin
            logic i_, t_, r_, g_, h_, ta, ra;
            int exp;
            {i_, t_, r_, g_, h_} = 5'(c);
            @(negedge clk);
            idle = i_; tx = t_; rx = r_; cfg = g_; hp = h_; corr = 0;
            repeat (3 * n_div) @(negedge clk);
            ta = !i_ && t_;
            ra = !i_ && r_ && !t_;
            exp = {i_, !ta, !ra, !(i_ || ta || (ra && g_)), ta, !ta, ta && h_, 3'b111};
            chk("R3 R4 R5 R6 steady outputs", vec10(), exp);
        end
    endtask

    task automatic run_corr(input int k, input string tag);
        int f = -1, m_hold = 0, m_pulse = 0, m_pwm = 0, total;
        total = (k + 4) * n_div;
        @(negedge clk);
        idle = 1'b0; tx = 0; rx = 1; cfg = 0;
        corr = 1'b1;
        for (int i = 0; i < total; i++) begin
            @(negedge clk);
            smp[i] = {hold_n, pulse_n, pwm_n};
            if (i == k * n_div - 1) corr = 1'b0;
        end
        for (int i = 0; i < total; i++) if (f < 0 && smp[i][2] == 1'b0) f = i;
        chk({tag, " R8 start latency within one tick"}, (f >= 0 && f < n_div) ? 1 : 0, 1);
        if (f < 0) f = 0;
        for (int i = f; i < f + (k + 2) * n_div; i++) begin
            int j;
            logic eh, ep, ew;
            j = (i - f) / n_div;
            if (j < k) begin
                eh = 1'b0;
                ep = (j < 120) ? 1'b0 : 1'b1;
                ew = (j < 120) ? 1'b0 : (((j - 120) % 8) == 7 ? 1'b0 : 1'b1);
            end else begin
                eh = 1'b1; ep = 1'b1; ew = 1'b1;
            end
            if (smp[i][2] != eh) m_hold++;
            if (smp[i][1] != ep) m_pulse++;
            if (smp[i][0] != ew) m_pwm++;
        end
        chk({tag, " R8 hold pattern mismatches"}, m_hold, 0);
        chk({tag, " R9 window pattern mismatches"}, m_pulse, 0);
        chk({tag, " R10 pwm pattern mismatches"}, m_pwm, 0);
    endtask

    task automatic run_idle_corr();
        @(negedge clk);
        idle = 1'b1; corr = 1'b1;
        repeat (3 * n_div) @(negedge clk);
        chk("R8 correlation ignored in idle", {hold_n, pulse_n, pwm_n}, 3'b111);
        corr = 1'b0;
    endtask

    initial begin
        for (int s = 0; s < 4; s++) begin
            do_reset(2'(s));
            run_ref();
            run_combos();
            run_corr(200, "full");
            run_corr(50, "R11 early end in window");
            run_corr(130, "R11 early end in pwm period");
            run_corr(120, "R11 restart");
            run_idle_corr();
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #1_900_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule